// File: doc/BRIEF.md
# Paged Address Translator with Tagged TLB

This block maps a virtual address to a physical address. The upper bits of the virtual address form a page number and the lower bits form an offset. The page number selects one entry of a single-level page table that sits in memory. A small fully associative TLB sits in front of that table, and each TLB line holds a page number, the address-space identifier that owns it, and a frame number. When the page number and the current identifier both match a line, the block returns that frame with the offset appended below it, and memory is not read.

On a miss the block first tests the page number against the table length input. If the page is in range, the block reads one word at the table base plus the page number through a read port with one cycle of latency. It then tests the valid bit in that word. A valid word is written into the TLB at the round-robin victim slot and the translation completes. An out-of-range page or an invalid word ends the request with a fault, and a faulting translation never enters the TLB. A flush input empties the TLB. The requester offers one request at a time and waits while `req_rdy` is low.

Top module: `vmap_xlat`

## Requirements
- R1: A request whose page number (va[VA_W-1:PG_W]) and identifier match a TLB line returns resp_vld in the cycle after acceptance, with resp_pa = {line frame, va[PG_W-1:0]} and resp_fault = 0. It issues no memory read, even if the table word has changed since the fill.
- R2: A page number greater than or equal to ptlr produces resp_vld with resp_fault = 1 and resp_fkind = 0 in the cycle after acceptance, with no memory read. This check is made before the TLB lookup.
- R3: An in-range miss raises mem_rd for exactly one cycle, in the cycle after acceptance, with mem_addr = ptbr + page number.
- R4: A table word has its valid flag in bit FR_W (the MSB) and the frame in bits FR_W-1:0. A valid word gives resp_vld four cycles after the mem_rd cycle, with resp_pa = {frame, offset}. An invalid word gives resp_fault = 1 and resp_fkind = 1 two cycles after the mem_rd cycle.
- R5: A request that faulted on an invalid word leaves no TLB line behind, so the same request made again reads memory again.
- R6: A hit requires the identifier to match. The same page under a different identifier misses and reads the table.
- R7: The TLB has TLB_N (4) lines, and fills take slots in round-robin order. The fill after TLB_N fills replaces the oldest line.
- R8: A flush pulse invalidates every line, so each later request misses.
- R9: req_rdy is low from the mem_rd cycle until the response of that miss, and high otherwise.
- R10: After reset req_rdy is 1, resp_vld is 0, mem_rd is 0 and the TLB is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all TLB lines |
| ptbr | input | MA_W | Table base word address |
| ptlr | input | VPN_W+1 | Table length in entries |
| req_vld | input | 1 | Request offered |
| req_rdy | output | 1 | Request accepted when high with req_vld |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Address-space identifier |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | MA_W | Table read address |
| mem_rdata | input | FR_W+1 | Table word, valid the cycle after mem_rd |
| resp_vld | output | 1 | Response pulse |
| resp_fault | output | 1 | Translation refused |
| resp_fkind | output | 1 | 0 = out of range, 1 = invalid entry |
| resp_pa | output | PA_W | Physical address |

## Verification
The hardest case to reach is replacement. A victim is only evicted after TLB_N distinct fills, and the faulting requests must not advance the fill pointer. To get there, the stimulus mixes misses under two identifiers, an out-of-range request and an invalid-entry fault, and then performs exactly one more fill. It then checks that only the oldest line was lost. Stale-hit behaviour is shown by rewriting a table word after its fill, so a hit returns the old frame while a request under another identifier returns the new one.

// File: rtl/vmap_xlat.sv
module vmap_xlat #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 20,
  parameter int PG_W   = 8,
  parameter int ASID_W = 4,
  parameter int MA_W   = 12,
  parameter int TLB_N  = 4,
  localparam int VPN_W = VA_W - PG_W,
  localparam int FR_W  = PA_W - PG_W,
  localparam int PTE_W = FR_W + 1,
  localparam int IX_W  = $clog2(TLB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [MA_W-1:0]   ptbr,
  input  logic [VPN_W:0]    ptlr,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  output logic              mem_rd,
  output logic [MA_W-1:0]   mem_addr,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              resp_vld,
  output logic              resp_fault,
  output logic              resp_fkind,
  output logic [PA_W-1:0]   resp_pa
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CK, S_FILL, S_DONE} st_t;
  st_t st;

  logic [TLB_N-1:0]  t_vld;
  logic [VPN_W-1:0]  t_vpn  [TLB_N];
  logic [ASID_W-1:0] t_asid [TLB_N];
  logic [FR_W-1:0]   t_fr   [TLB_N];
  logic [IX_W-1:0]   rr;

  logic [VPN_W-1:0]  vpn_q;
  logic [PG_W-1:0]   off_q;
  logic [ASID_W-1:0] asid_q;
  logic [FR_W-1:0]   fr_q;

  logic [VPN_W-1:0] req_vpn;
  logic [TLB_N-1:0] hit_vec;
  logic [FR_W-1:0]  hit_fr;
  logic             acc, oor;

  assign req_vpn = req_va[VA_W-1:PG_W];
  assign req_rdy = (st == S_IDLE);
  assign acc     = req_vld && req_rdy;
  assign oor     = {1'b0, req_vpn} >= ptlr;
  assign mem_rd  = (st == S_RD);
  assign mem_addr = ptbr + MA_W'(vpn_q);

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hit_vec[i] = t_vld[i] && (t_vpn[i] == req_vpn) && (t_asid[i] == req_asid);
  end

  always_comb begin
    hit_fr = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) hit_fr = hit_fr | t_fr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      t_vld <= '0;
      rr <= '0;
      vpn_q <= '0;
      off_q <= '0;
      asid_q <= '0;
      fr_q <= '0;
      resp_vld <= 1'b0;
      resp_fault <= 1'b0;
      resp_fkind <= 1'b0;
      resp_pa <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        t_vpn[i] <= '0;
        t_asid[i] <= '0;
        t_fr[i] <= '0;
      end
    end else begin
      resp_vld <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          vpn_q  <= req_vpn;
          off_q  <= req_va[PG_W-1:0];
          asid_q <= req_asid;
          if (oor) begin
            resp_vld   <= 1'b1;
            resp_fault <= 1'b1;
            resp_fkind <= 1'b0;
            resp_pa    <= '0;
          end else if (|hit_vec) begin
            resp_vld   <= 1'b1;
            resp_fault <= 1'b0;
            resp_fkind <= 1'b0;
            resp_pa    <= {hit_fr, req_va[PG_W-1:0]};
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_CK;
        S_CK: begin
          if (!mem_rdata[PTE_W-1]) begin
            resp_vld   <= 1'b1;
            resp_fault <= 1'b1;
            resp_fkind <= 1'b1;
            resp_pa    <= '0;
            st <= S_IDLE;
          end else begin
            fr_q <= mem_rdata[FR_W-1:0];
            st <= S_FILL;
          end
        end
        S_FILL: begin
          t_vld[rr]  <= 1'b1;
          t_vpn[rr]  <= vpn_q;
          t_asid[rr] <= asid_q;
          t_fr[rr]   <= fr_q;
          rr <= (rr == IX_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
          st <= S_DONE;
        end
        S_DONE: begin
          resp_vld   <= 1'b1;
          resp_fault <= 1'b0;
          resp_fkind <= 1'b0;
          resp_pa    <= {fr_q, off_q};
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (flush) t_vld <= '0;
    end
  end

  // R7
  single_line_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

  // R2
  range_fault_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && resp_fault && !resp_fkind) |-> $past(acc));

  // R3
  fetch_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ({1'b0, vpn_q} < ptlr));

  // R3
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (hit_vec == '0));

endmodule

// File: tb/sim_vmap_xlat.sv
module sim_vmap_xlat;
  logic clk = 0, rst_n = 0, flush = 0, req_vld = 0;
  logic [11:0] ptbr = 12'h100;
  logic [8:0]  ptlr = 9'd40;
  logic [15:0] req_va = 0;
  logic [3:0]  req_asid = 0;
  logic [12:0] mem_rdata = 0;
  logic req_rdy, mem_rd, resp_vld, resp_fault, resp_fkind;
  logic [11:0] mem_addr;
  logic [19:0] resp_pa;

  always #2.5 clk = ~clk;

  vmap_xlat u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(ptbr), .ptlr(ptlr),
    .req_vld(req_vld), .req_rdy(req_rdy), .req_va(req_va), .req_asid(req_asid),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .resp_vld(resp_vld),
    .resp_fault(resp_fault), .resp_fkind(resp_fkind), .resp_pa(resp_pa));

  logic [12:0] pt [0:4095];
  always @(posedge clk) if (mem_rd) mem_rdata <= pt[mem_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit run = 0, pend = 0;
  int e_cyc = -1, rd_cyc = -1, bsy_lo = -1, bsy_hi = -2;
  bit e_fault, e_kind;
  logic [19:0] e_pa;
  logic [11:0] e_addr;
  string tag = "R10";

  bit m_vld [4];
  int m_vpn [4], m_asid [4], m_fr [4];
  int m_rr = 0;

  task automatic chk(input bit ok, input string t, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h cyc=%0d", t, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (run) begin
    if (pend && cyc == e_cyc) begin
      chk(resp_vld == 1, tag, "resp_vld", resp_vld, 1);
      chk(resp_fault == e_fault, tag, "fault", resp_fault, e_fault);
      if (e_fault) chk(resp_fkind == e_kind, tag, "fkind", resp_fkind, e_kind);
      else chk(resp_pa == e_pa, tag, "pa", resp_pa, e_pa);
      pend = 0;
    end else chk(resp_vld == 0, tag, "idle resp_vld", resp_vld, 0);
    chk(mem_rd == (cyc == rd_cyc), tag, "mem_rd", mem_rd, cyc == rd_cyc);
    if (cyc == rd_cyc) chk(mem_addr == e_addr, tag, "mem_addr", mem_addr, e_addr);
    chk(req_rdy == !(cyc >= bsy_lo && cyc <= bsy_hi), "R9", "req_rdy", req_rdy,
        !(cyc >= bsy_lo && cyc <= bsy_hi));
  end

  task automatic xl(input logic [15:0] va, input int asid, input string t);
    int vpn, a, hit;
    logic [12:0] w;
    @(negedge clk);
    while (!req_rdy) @(negedge clk);
    vpn = int'(va[15:8]);
    a = cyc + 1;
    tag = t;
    hit = -1;
    if (vpn >= int'(ptlr)) begin
      e_fault = 1; e_kind = 0; e_cyc = a;
    end else begin
      for (int i = 0; i < 4; i++)
        if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) hit = i;
      if (hit >= 0) begin
        e_fault = 0; e_pa = {12'(m_fr[hit]), va[7:0]}; e_cyc = a;
      end else begin
        e_addr = ptbr + 12'(vpn);
        w = pt[e_addr];
        rd_cyc = a;
        bsy_lo = a;
        if (!w[12]) begin
          e_fault = 1; e_kind = 1; e_cyc = a + 2; bsy_hi = a + 1;
        end else begin
          e_fault = 0; e_pa = {w[11:0], va[7:0]}; e_cyc = a + 4; bsy_hi = a + 3;
          m_vld[m_rr] = 1; m_vpn[m_rr] = vpn; m_asid[m_rr] = asid; m_fr[m_rr] = int'(w[11:0]);
          m_rr = (m_rr + 1) % 4;
        end
      end
    end
    pend = 1;
    req_va = va; req_asid = 4'(asid); req_vld = 1;
    @(negedge clk);
    req_vld = 0;
    while (pend) @(negedge clk);
  endtask

  task automatic do_flush;
    @(negedge clk);
    flush = 1;
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
    @(negedge clk);
    flush = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) pt[i] = 13'h0;
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_fr[i] = 0; end
    pt[12'h105] = {1'b1, 12'hA05};
    pt[12'h127] = {1'b1, 12'h427};
    pt[12'h107] = {1'b0, 12'h777};
    pt[12'h108] = {1'b1, 12'h808};
    repeat (3) @(negedge clk);
    chk(req_rdy == 1, "R10", "rdy in reset", req_rdy, 1);
    chk(resp_vld == 0, "R10", "resp in reset", resp_vld, 0);
    chk(mem_rd == 0, "R10", "mem_rd in reset", mem_rd, 0);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    xl(16'h0512, 1, "R3");
    xl(16'h05AB, 1, "R1");
    pt[12'h105] = {1'b1, 12'h333};
    xl(16'h05CD, 1, "R1");
    xl(16'h0511, 2, "R6");
    xl(16'h0522, 1, "R6");
    xl(16'h3001, 1, "R2");
    xl(16'h2800, 2, "R2");
    xl(16'h27FF, 1, "R4");
    xl(16'h0733, 1, "R4");
    pt[12'h107] = {1'b1, 12'h707};
    xl(16'h0744, 1, "R5");
    xl(16'h0855, 1, "R7");
    xl(16'h0566, 1, "R7");
    xl(16'h0877, 1, "R7");
    do_flush();
    xl(16'h0899, 1, "R8");
    xl(16'h0899, 1, "R8");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule